// File: doc/BRIEF.md
# Atomic Set/Clear Output Port

This block owns a bank of general-purpose output bits and the register interface that software uses to change them. The outputs can be loaded whole through a data register. They can also be changed bit by bit through two write-only command registers. One is a double-width set/clear word: its lower half raises the outputs whose bits are 1, and its upper half lowers them. The other is a clear-only word. Because the commands carry only the bits that must change, a program never reads, edits and writes back the output word. That removes the race in which an interrupt handler changes other bits between the read and the write.

The output register can be read back, so software toggles pins with one read followed by one set/clear write built from that value. A second readable register returns the input pin levels after a chain of synchronising flops. Pad drivers, pull resistors and peripheral routing sit outside this block.

The bus is a single-cycle strobe interface. A write takes effect at the clock edge on which it is presented. A read returns its value in `bus_rdata` after that same edge, and `bus_rdata` holds that value until the next read.

Top module: `gpo_port`

## Requirements
- R1: After a synchronous reset, `pins_out` is all zeros, and a read of the data register (word address 1) returns zero.
- R2: A write to the set/clear register (word address 2) with bit n = 1, for n below NPINS, drives `pins_out[n]` high from the next clock edge.
- R3: A write to the set/clear register with bit n+NPINS = 1 and bit n = 0 drives `pins_out[n]` low.
- R4: A bit written as 0 in both halves of the set/clear register keeps its output unchanged. Cycles with no write to word addresses 1, 2 or 3 leave `pins_out` unchanged.
- R5: When one set/clear write has both bit n and bit n+NPINS at 1, output n ends high, because the set wins.
- R6: A write to the clear-only register (word address 3) with bit n = 1 lowers `pins_out[n]`. Its bits at NPINS and above have no effect.
- R7: A write to the data register loads `pins_out` with the low NPINS bits of the write data. The upper bits are ignored.
- R8: A read of the data register returns the current `pins_out` value, zero-extended.
- R9: Reads of the set/clear and clear-only registers return zero.
- R10: A read of the input register (word address 0) returns `pins_in` after SYNC_STAGES synchronising flops, zero-extended.
- R11: A toggle made by reading the data register and then writing the set/clear register with set = ~value & mask and clear = value & mask inverts exactly the masked outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 2 | Word address: 0 input levels, 1 output data, 2 set/clear, 3 clear-only |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pins_in | input | 16 | Asynchronous input pin levels |
| pins_out | output | 16 | Registered output levels |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` carry defined values whenever `bus_wr` is high, and that reads and writes are single-cycle strobes. Given that, every write can be traced to exactly one register update at the next edge. The stimulus changes the bus only on the falling edge, drives fully specified words, and issues at most one operation per cycle with idle cycles between. It also holds `pins_in` steady for more than SYNC_STAGES cycles before it reads the input register, so the synchroniser latency never affects the expected value.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  // Word addresses of the port registers.
  typedef enum logic [1:0] {
    REG_LEVEL  = 2'd0,
    REG_DATA   = 2'd1,
    REG_SETCLR = 2'd2,
    REG_CLR    = 2'd3
  } gpo_reg_e;
endpackage

// File: rtl/gpo_decode.sv
module gpo_decode (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  output logic                wr_data,
  output logic                wr_setclr,
  output logic                wr_clr,
  output gpo_pkg::gpo_reg_e   rd_sel,
  output logic                rd_en
);
  import gpo_pkg::*;

  gpo_reg_e sel;
  assign sel = gpo_reg_e'(bus_addr);

  always_comb begin
    wr_data   = bus_wr && (sel == REG_DATA);
    wr_setclr = bus_wr && (sel == REG_SETCLR);
    wr_clr    = bus_wr && (sel == REG_CLR);
    rd_en     = bus_rd;
    rd_sel    = sel;
  end

  // Write strobes for different registers never coincide.
  p_onehot_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_data, wr_setclr, wr_clr}));
endmodule

// File: rtl/gpo_sync.sv
module gpo_sync #(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);
  logic [SYNC_STAGES-1:0][NPINS-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[SYNC_STAGES-1];

  // The first stage captures the pin levels one edge later.
  p_first_stage_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> chain[0] == $past(d));
endmodule

// File: rtl/gpo_out_reg.sv
module gpo_out_reg #(
  parameter int NPINS = 16,
  localparam int DW   = 2 * NPINS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_setclr,
  input  logic             wr_clr,
  input  logic [DW-1:0]    wdata,
  output logic [NPINS-1:0] q
);
  logic [NPINS-1:0] set_m, clr_m, nxt;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (wr_setclr) begin
      set_m = wdata[NPINS-1:0];
      clr_m = wdata[DW-1:NPINS];
    end else if (wr_clr) begin
      clr_m = wdata[NPINS-1:0];
    end
    // The set mask is applied last, so it wins over a clear of the same bit.
    if (wr_data) nxt = wdata[NPINS-1:0];
    else         nxt = (q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_data || wr_setclr || wr_clr) |=> $stable(q));

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> q == $past(wdata[NPINS-1:0]));

  for (genvar i = 0; i < NPINS; i++) begin : g_bit_chk
    p_set_r2_r5: assert property (@(posedge clk) disable iff (rst)
      wr_setclr && wdata[i] |=> q[i]);
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      wr_setclr && wdata[i+NPINS] && !wdata[i] |=> !q[i]);
    p_keep_r4: assert property (@(posedge clk) disable iff (rst)
      wr_setclr && !wdata[i] && !wdata[i+NPINS] |=> $stable(q[i]));
    p_clr_only_r6: assert property (@(posedge clk) disable iff (rst)
      wr_clr && wdata[i] |=> !q[i]);
  end
endmodule

// File: rtl/gpo_port.sv
module gpo_port #(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = 2 * NPINS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pins_in,
  output logic [NPINS-1:0] pins_out
);
  import gpo_pkg::*;

  logic             wr_data, wr_setclr, wr_clr, rd_en;
  gpo_reg_e         rd_sel;
  logic [NPINS-1:0] level;

  gpo_decode u_dec (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .wr_data(wr_data), .wr_setclr(wr_setclr), .wr_clr(wr_clr),
    .rd_sel(rd_sel), .rd_en(rd_en)
  );

  gpo_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .q(level)
  );

  gpo_out_reg #(.NPINS(NPINS)) u_out (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_setclr(wr_setclr),
    .wr_clr(wr_clr), .wdata(bus_wdata), .q(pins_out)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    unique case (rd_sel)
      REG_LEVEL: rd_mux = {{NPINS{1'b0}}, level};
      REG_DATA:  rd_mux = {{NPINS{1'b0}}, pins_out};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  p_wo_zero_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr[1] |=> bus_rdata == '0);

  p_readback_r8: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == 2'd1 |=> bus_rdata[NPINS-1:0] == $past(pins_out));
endmodule

// File: tb/gpo_port_tb.sv
module gpo_port_tb;
  localparam int N  = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0] pins_in = '0;
  logic [N-1:0] pins_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpo_port u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in), .pins_out(pins_out)
  );

  // Fields: address, write data, expected outputs after the write.
  localparam logic [49:0] VEC [0:9] = '{
    {2'd1, 32'h0000_A5A5, 16'hA5A5},   // R7 load
    {2'd2, 32'h0000_0F00, 16'hAFA5},   // R2 set
    {2'd2, 32'h00A5_0000, 16'hAF00},   // R3 clear
    {2'd2, 32'h0000_0000, 16'hAF00},   // R4 zero word
    {2'd2, 32'h0003_0001, 16'hAF01},   // R5 set wins
    {2'd3, 32'h0000_8001, 16'h2F00},   // R6 clear-only
    {2'd3, 32'hFFFF_0000, 16'h2F00},   // R6 upper bits ignored
    {2'd1, 32'hFFFF_1234, 16'h1234},   // R7 upper bits ignored
    {2'd2, 32'hFFFF_FFFF, 16'hFFFF},   // R5 all set wins
    {2'd2, 32'hFFFF_0000, 16'h0000}    // R3 clear all
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [DW-1:0] rv;
    logic [N-1:0] odr, msk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pins_out", {16'h0, pins_out}, 32'h0);
    bus_read(2'd1, rv);
    check("R1 data read", rv, 32'h0);

    for (int i = 0; i < 10; i++) begin
      bus_write(VEC[i][49:48], VEC[i][47:16]);
      check($sformatf("vector %0d pins_out (R2..R7)", i), {16'h0, pins_out}, {16'h0, VEC[i][15:0]});
      bus_read(2'd1, rv);
      check($sformatf("R8 readback vector %0d", i), rv, {16'h0, VEC[i][15:0]});
    end

    // R4 idle cycles keep outputs
    bus_write(2'd1, 32'h0000_3C3C);
    repeat (5) @(negedge clk);
    check("R4 idle hold", {16'h0, pins_out}, 32'h0000_3C3C);

    // R9 write-only registers read zero
    bus_read(2'd2, rv);
    check("R9 setclr read", rv, 32'h0);
    bus_read(2'd3, rv);
    check("R9 clr read", rv, 32'h0);
    check("R9 reads left outputs", {16'h0, pins_out}, 32'h0000_3C3C);

    // R10 synchronised input levels
    pins_in = 16'hC3C3;
    repeat (4) @(negedge clk);
    bus_read(2'd0, rv);
    check("R10 level read", rv, 32'h0000_C3C3);
    pins_in = 16'h0001;
    repeat (4) @(negedge clk);
    bus_read(2'd0, rv);
    check("R10 level read 2", rv, 32'h0000_0001);

    // R11 toggle via read then set/clear write
    bus_write(2'd1, 32'h0000_00FF);
    bus_read(2'd1, rv);
    odr = rv[N-1:0];
    msk = 16'h0F0F;
    bus_write(2'd2, {odr & msk, ~odr & msk});
    check("R11 toggle", {16'h0, pins_out}, 32'h0000_0FF0);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset clears outputs", {16'h0, pins_out}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule